// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block walks a list of descriptors held in memory and turns each one into a segment (address and byte count) for a hash datapath that follows it. A `start` pulse latches the list base address. For each entry the walker reads two 32-bit words over a single-outstanding memory read port. The length word comes first, then the address word. Once both words are back, the walker offers the decoded segment on a valid/ready output.

Each descriptor takes 8 bytes, so entry i sits at base + 8*i. The length word is at byte offset 0 of the entry and the address word at offset 4. Words are little-endian: `mem_rsp_data[7:0]` is the byte at the lowest address. Bit 31 of the length word flags the final entry, and that entry is still emitted. A parameter sets a hard limit on the number of entries. If the limit is reached without a final flag, the walk ends and reports an error. A one-cycle `done` pulse, carrying `done_err`, closes every walk.

Top module: `sgw_top`

## Requirements
- R1: For entry i the walker requests byte address base+8*i and then base+8*i+4, with the length word first. At most one read is outstanding, and no read is issued while a segment is offered. A walk of n entries issues exactly 2*n reads.
- R2: `seg_len` equals bits [27:0] of the entry's length word. Bits [30:28] of that word have no effect.
- R3: `seg_addr` equals the entry's address word with bit 31 forced to 0.
- R4: `seg_last` equals bit 31 of the length word. After the handshake of a flagged entry, no further reads or segments occur.
- R5: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr`, `seg_len` and `seg_last` hold their values.
- R6: If MAX_ENTRIES entries are emitted and none carries the final flag, the walk stops after the last of them and `done_err` is 1 with `done`.
- R7: `done` is high for exactly one cycle, in the cycle after the final segment handshake. A walk ended by the final flag reports `done_err` = 0, including when the flagged entry is entry MAX_ENTRIES-1.
- R8: A `start` pulse while `busy` is high is ignored, and a new `base_addr` presented then has no effect on the running walk.
- R9: After reset, `busy`, `mem_req_valid`, `seg_valid` and `done` are 0. In the idle state no read or segment is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| base_addr | input | 32 | Byte address of entry 0 |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid (one per accepted request, in order) |
| mem_rsp_data | input | 32 | Read data, little-endian |
| seg_valid | output | 1 | Segment valid |
| seg_ready | input | 1 | Segment accepted |
| seg_addr | output | 32 | Segment address, bit 31 cleared |
| seg_len | output | 28 | Segment byte count |
| seg_last | output | 1 | Segment came from the flagged entry |
| done | output | 1 | One-cycle end-of-walk pulse |
| done_err | output | 1 | Walk hit the entry limit without a final flag |

## Verification
Several properties are checked on every cycle:
- the segment stays stable under back-pressure;
- a read request and a segment offer never overlap;
- `done` lasts one cycle and follows a segment handshake;
- an error completion always coincides with a full count of entries;
- the idle state presents nothing.

Other behaviour only the bench scenarios can show, by comparing each walk against a model built from the memory contents:
- the address sequence of the reads and the order of the two words;
- the masking of the length and address fields;
- the stop on the final flag, the limit-exact cases, and that a start during a walk is ignored.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LEN_BITS   = 28;
  localparam int unsigned FLAG_BIT   = 31;
  localparam int unsigned ENTRY_SIZE = 8;
  localparam int unsigned ADR_OFFSET = 4;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_REQ_LEN  = 3'd1,
    ST_WAIT_LEN = 3'd2,
    ST_REQ_ADR  = 3'd3,
    ST_WAIT_ADR = 3'd4,
    ST_EMIT     = 3'd5,
    ST_DONE     = 3'd6
  } walk_state_e;
endpackage

// File: rtl/sgw_decode.sv
module sgw_decode
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_KEEP = 31
) (
  input  logic [WORD_W-1:0]   len_word,
  input  logic [WORD_W-1:0]   adr_word,
  output logic [LEN_BITS-1:0] seg_len,
  output logic [WORD_W-1:0]   seg_addr,
  output logic                final_flag
);
  localparam logic [WORD_W-1:0] ADDR_MASK = (WORD_W'(1) << ADDR_KEEP) - WORD_W'(1);

  always_comb begin
    seg_len    = len_word[LEN_BITS-1:0];
    seg_addr   = adr_word & ADDR_MASK;
    final_flag = len_word[FLAG_BIT];
  end
endmodule

// File: rtl/sgw_limit.sv
module sgw_limit #(
  parameter int unsigned MAX_ENTRIES = 32,
  localparam int unsigned CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic             at_limit,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (clr)      count_d = '0;
    else if (inc) count_d = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (clr || inc) count <= count_d;
  end

  assign at_limit = (count == CNT_W'(MAX_ENTRIES - 1));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(MAX_ENTRIES));
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 32,
  localparam int unsigned CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] base_addr,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic [WORD_W-1:0] len_word,
  output logic [WORD_W-1:0] adr_word,
  input  logic              final_flag,
  input  logic              at_limit,
  input  logic [CNT_W-1:0]  count,
  output logic              cnt_clr,
  output logic              cnt_inc,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic              done,
  output logic              done_err
);
  walk_state_e       state_q, state_d;
  logic [WORD_W-1:0] cursor_q, cursor_d;
  logic              err_q, err_d;
  logic              len_en, adr_en, cursor_en, err_en;
  logic              seg_hs;

  assign seg_hs = seg_valid && seg_ready;

  always_comb begin
    state_d   = state_q;
    cursor_d  = cursor_q;
    err_d     = err_q;
    len_en    = 1'b0;
    adr_en    = 1'b0;
    cursor_en = 1'b0;
    err_en    = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d   = ST_REQ_LEN;
        cursor_d  = base_addr;
        cursor_en = 1'b1;
        cnt_clr   = 1'b1;
        err_d     = 1'b0;
        err_en    = 1'b1;
      end
      ST_REQ_LEN:  if (mem_req_ready) state_d = ST_WAIT_LEN;
      ST_WAIT_LEN: if (mem_rsp_valid) begin
        len_en  = 1'b1;
        state_d = ST_REQ_ADR;
      end
      ST_REQ_ADR:  if (mem_req_ready) state_d = ST_WAIT_ADR;
      ST_WAIT_ADR: if (mem_rsp_valid) begin
        adr_en  = 1'b1;
        state_d = ST_EMIT;
      end
      ST_EMIT: if (seg_ready) begin
        cnt_inc = 1'b1;
        if (final_flag || at_limit) begin
          state_d = ST_DONE;
          err_d   = !final_flag;
          err_en  = 1'b1;
        end else begin
          state_d   = ST_REQ_LEN;
          cursor_d  = cursor_q + WORD_W'(ENTRY_SIZE);
          cursor_en = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cursor_q <= '0;
      err_q    <= 1'b0;
      len_word <= '0;
      adr_word <= '0;
    end else begin
      state_q <= state_d;
      if (cursor_en) cursor_q <= cursor_d;
      if (err_en)    err_q    <= err_d;
      if (len_en)    len_word <= mem_rsp_data;
      if (adr_en)    adr_word <= mem_rsp_data;
    end
  end

  always_comb begin
    busy          = (state_q != ST_IDLE);
    mem_req_valid = (state_q == ST_REQ_LEN) || (state_q == ST_REQ_ADR);
    mem_req_addr  = (state_q == ST_REQ_ADR) ? cursor_q + WORD_W'(ADR_OFFSET) : cursor_q;
    seg_valid     = (state_q == ST_EMIT);
    done          = (state_q == ST_DONE);
    done_err      = (state_q == ST_DONE) && err_q;
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(len_word) && $stable(adr_word));
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(seg_valid && mem_req_valid));
  assert_req_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(seg_hs));
  assert_err_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err |-> count == CNT_W'(MAX_ENTRIES));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !seg_valid && !done);
endmodule

// File: rtl/sgw_top.sv
module sgw_top
  import sgw_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 32,
  parameter int unsigned ADDR_KEEP   = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [31:0]         base_addr,
  output logic                busy,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [31:0]         mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [31:0]         mem_rsp_data,
  output logic                seg_valid,
  input  logic                seg_ready,
  output logic [31:0]         seg_addr,
  output logic [27:0]         seg_len,
  output logic                seg_last,
  output logic                done,
  output logic                done_err
);
  localparam int unsigned CNT_W = $clog2(MAX_ENTRIES + 1);

  logic [WORD_W-1:0] len_word, adr_word;
  logic              final_flag, at_limit, cnt_clr, cnt_inc;
  logic [CNT_W-1:0]  count;

  sgw_ctrl #(.MAX_ENTRIES(MAX_ENTRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .len_word(len_word), .adr_word(adr_word),
    .final_flag(final_flag), .at_limit(at_limit), .count(count),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .seg_valid(seg_valid),
    .seg_ready(seg_ready), .done(done), .done_err(done_err)
  );

  sgw_limit #(.MAX_ENTRIES(MAX_ENTRIES)) u_limit (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .at_limit(at_limit), .count(count)
  );

  sgw_decode #(.ADDR_KEEP(ADDR_KEEP)) u_decode (
    .len_word(len_word), .adr_word(adr_word), .seg_len(seg_len),
    .seg_addr(seg_addr), .final_flag(final_flag)
  );

  assign seg_last = final_flag;

  assert_last_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_ready && seg_last |=> done && !done_err);
endmodule

// File: tb/sgw_top_test.sv
module sgw_top_test;
  localparam int MAXE = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic        busy, mem_req_valid, mem_rsp_valid, seg_valid, seg_last, done, done_err;
  logic        mem_req_ready, seg_ready;
  logic [31:0] mem_req_addr, mem_rsp_data, seg_addr;
  logic [27:0] seg_len;

  always #4 clk = ~clk;

  sgw_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .done(done), .done_err(done_err)
  );

  int          checks = 0;
  int          errors = 0;
  logic [31:0] mem [0:255];
  int          ready_pct = 100;

  // memory responder and sink back-pressure
  logic       pend = 1'b0;
  logic [7:0] paddr = '0;
  int         dly = 0;
  int         req_n = 0;
  initial begin mem_req_ready = 1'b0; seg_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; end
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[paddr];
        pend <= 1'b0;
      end else dly <= dly - 1;
    end
    if (mem_req_valid && mem_req_ready) begin
      pend  <= 1'b1;
      paddr <= mem_req_addr[9:2];
      dly   <= $urandom % 3;
      req_n <= req_n + 1;
    end
    mem_req_ready <= (($urandom % 100) < ready_pct);
    seg_ready     <= (($urandom % 100) < ready_pct);
  end

  // segment and completion collector
  logic [31:0] got_addr [0:63];
  logic [27:0] got_len  [0:63];
  logic        got_last [0:63];
  int          seg_n = 0, done_n = 0, hold_bad = 0;
  logic        last_err = 1'b0;
  logic        prev_stall = 1'b0;
  logic [60:0] prev_seg = '0;
  always @(posedge clk) begin
    if (seg_valid && seg_ready) begin
      got_addr[seg_n % 64] <= seg_addr;
      got_len[seg_n % 64]  <= seg_len;
      got_last[seg_n % 64] <= seg_last;
      seg_n <= seg_n + 1;
    end
    if (prev_stall && !(seg_valid && {seg_addr, seg_len, seg_last} == prev_seg))
      hold_bad <= hold_bad + 1;
    prev_stall <= seg_valid && !seg_ready;
    prev_seg   <= {seg_addr, seg_len, seg_last};
    if (done) begin
      done_n   <= done_n + 1;
      last_err <= done_err;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // walk: model the list, run the design, compare
  task automatic walk(input logic [31:0] base, input bit poke_start);
    logic [31:0] e_addr [0:63];
    logic [27:0] e_len  [0:63];
    logic        e_last [0:63];
    int n = 0;
    bit term = 0;
    int s0, d0, r0, t;
    for (int i = 0; i < MAXE && !term; i++) begin
      logic [31:0] lw, aw;
      lw = mem[8'(base[9:2] + 8'(2*i))];
      aw = mem[8'(base[9:2] + 8'(2*i+1))];
      e_len[i]  = lw[27:0];
      e_addr[i] = aw & 32'h7FFF_FFFF;
      e_last[i] = lw[31];
      term = lw[31];
      n++;
    end
    @(negedge clk);
    s0 = seg_n; d0 = done_n; r0 = req_n;
    base_addr = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_start) begin
      repeat (2) @(negedge clk);
      base_addr = base + 32'h40; start = 1'b1;
      @(negedge clk);
      start = 1'b0; base_addr = base;
    end
    t = 0;
    while (done_n == d0 && t < 5000) begin @(negedge clk); t++; end
    chk(done_n == d0 + 1, "R7 done seen", 64'(done_n - d0), 64'd1);
    chk(last_err == !term, term ? "R7 err clear" : "R6 err set", 64'(last_err), 64'(!term));
    repeat (10) @(negedge clk);
    chk(seg_n - s0 == n, poke_start ? "R8 segment count" : "R4 segment count", 64'(seg_n - s0), 64'(n));
    chk(req_n - r0 == 2*n, "R1 read count", 64'(req_n - r0), 64'(2*n));
    chk(done_n == d0 + 1, "R7 single done", 64'(done_n - d0), 64'd1);
    for (int k = 0; k < n && k < seg_n - s0; k++) begin
      chk(got_len[(s0+k)%64] == e_len[k], "R2 seg_len", 64'(got_len[(s0+k)%64]), 64'(e_len[k]));
      chk(got_addr[(s0+k)%64] == e_addr[k], "R3 seg_addr", 64'(got_addr[(s0+k)%64]), 64'(e_addr[k]));
      chk(got_last[(s0+k)%64] == e_last[k], "R4 seg_last", 64'(got_last[(s0+k)%64]), 64'(e_last[k]));
    end
  endtask

  task automatic fill_list(input logic [31:0] base, input int n, input bit terminate);
    for (int i = 0; i < n; i++) begin
      logic [31:0] lw;
      lw = $urandom;
      lw[31] = terminate && (i == n - 1);
      mem[8'(base[9:2] + 8'(2*i))]   = lw;
      mem[8'(base[9:2] + 8'(2*i+1))] = $urandom;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 32'h8000_0000;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req_valid && !seg_valid && !done, "R9 reset state",
        64'({busy, mem_req_valid, seg_valid, done}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req_valid && !seg_valid, "R9 idle after reset",
        64'({busy, mem_req_valid, seg_valid}), 64'd0);

    // directed: single flagged entry with masked bits set
    mem[16] = 32'hF123_4567; mem[17] = 32'hFFFF_FFF0;
    walk(32'h40, 0);
    // directed: no terminator within limit -> error
    fill_list(32'h0, MAXE, 0);
    walk(32'h0, 0);
    // directed: flag exactly on the last allowed entry
    fill_list(32'h100, MAXE, 1);
    walk(32'h100, 0);
    // directed: start pulse during a walk with heavy back-pressure
    ready_pct = 30;
    fill_list(32'h20, 6, 1);
    walk(32'h20, 1);
    // random lists
    for (int r = 0; r < 20; r++) begin
      logic [31:0] b;
      int n;
      ready_pct = 40 + ($urandom % 61);
      b = ($urandom % 120) * 4;
      n = 1 + ($urandom % 12);
      fill_list(b, n, 1);
      walk(b, r % 4 == 0);
    end
    chk(hold_bad == 0, "R5 segment held under stall", 64'(hold_bad), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule